// File: doc/BRIEF.md
# Sampling-Phase Calibration Controller

This block centres the sampling point of many serial receive lanes without software help. While the far end repeats a known training word, the controller takes one lane at a time. It steps that lane's delay line through every tap. At each tap it waits a fixed settling time and then watches a fixed number of received words, using the match flag from an external word comparator. The block records which taps passed and finds the longest run of adjacent passing taps. It then programs the tap in the middle of that run.

Both ends run from one frequency source, so the phase found at start-up stays valid. The controller is therefore run once after power-up, or again when asked. The chosen tap and a no-window flag are kept for every lane and can be read back by lane index. The delay element, the deserializer and the word comparator sit outside this block.

Top module: `phase_cal_ctrl`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `tap_load_o` are low, and every stored lane entry reads tap 0 with no fail flag.
- R2: A `start_i` pulse while idle begins a sweep at lane 0, tap 0. A `start_i` pulse during a sweep has no effect on its course or its results.
- R3: For each tap, `tap_load_o` is high for exactly one cycle with `tap_o` equal to the tap. Next come SETTLE cycles in which words are ignored, and then exactly WORDS words are counted. A word counts only in a cycle with `word_valid_i` high, and `match_i` is ignored when `word_valid_i` is low.
- R4: A tap passes only if `match_i` is high on every one of its WORDS counted words. A single mismatching word fails the tap.
- R5: The window is the longest run of adjacent passing taps. When two runs have equal length, the lower run wins.
- R6: Once every tap of a lane has been tested, the chosen tap is floor((first + last) / 2) of the window. It is sent as the lane's final `tap_o`/`tap_load_o` strobe and stored for that lane.
- R7: If no tap of a lane passes, that lane's fail flag is set, tap 0 is stored and loaded, and the sweep moves on to the next lane.
- R8: Lanes are calibrated in ascending order 0 to NUM_CH-1. `chan_o` changes only by stepping up by one, and each lane receives TAPS+1 load strobes.
- R9: `busy_o` is high from the start until the last lane is finished. `done_o` then rises and holds until the next accepted start. The two are never high together.
- R10: `rd_ch_i` selects a lane, and `rd_tap_o`/`rd_fail_o` show that lane's stored result in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a calibration sweep (idle only) |
| word_valid_i | input | 1 | A received word is present this cycle |
| match_i | input | 1 | That word equals the training pattern |
| tap_o | output | TAP_W | Tap value for the delay element |
| tap_load_o | output | 1 | Load strobe for `tap_o` |
| chan_o | output | CH_W | Lane currently being calibrated |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | All lanes finished |
| rd_ch_i | input | CH_W | Readback lane select |
| rd_tap_o | output | TAP_W | Stored tap of the selected lane |
| rd_fail_o | output | 1 | Selected lane found no passing tap |

## Verification
A corrupted run-length or run-start register shows up only at the end of a lane, as a wrong final load value and a wrong stored tap. That is up to TAPS x (SETTLE+WORDS) cycles after the fault, so every lane's final load and readback are compared with a model. A word counter that miscounts, or that counts while `word_valid_i` is low, changes which taps pass. It also changes the sweep length. The bench therefore drives mismatches in invalid and settling cycles, and places a single bad word inside the window. A sequencing fault shows within a lane as a wrong number of load strobes or a skipped lane index.

// File: rtl/pc_pkg.sv
package pc_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_SETTLE, S_MEAS, S_EVAL, S_APPLY, S_NEXT
  } pc_state_e;
endpackage

// File: rtl/pc_cycle_cnt.sv
module pc_cycle_cnt #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_o;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_o + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_o <= '0;
    else        cnt_o <= cnt_d;
  end
endmodule

// File: rtl/pc_win_track.sv
module pc_win_track #(
  parameter int TAPS  = 32,
  parameter int TAP_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             upd,
  input  logic             pass,
  input  logic [TAP_W-1:0] tap,
  output logic             found_o,
  output logic [TAP_W-1:0] centre_o
);
  localparam int LEN_W = $clog2(TAPS + 1);

  logic [TAP_W-1:0] cur_start_q, cur_start_d, best_start_q, best_start_d;
  logic [LEN_W-1:0] cur_len_q, cur_len_d, best_len_q, best_len_d;
  logic [LEN_W-1:0] half_len;

  always_comb begin
    cur_start_d  = cur_start_q;
    cur_len_d    = cur_len_q;
    best_start_d = best_start_q;
    best_len_d   = best_len_q;
    if (clr) begin
      cur_start_d  = '0;
      cur_len_d    = '0;
      best_start_d = '0;
      best_len_d   = '0;
    end else if (upd) begin
      if (pass) begin
        cur_len_d   = cur_len_q + 1'b1;
        cur_start_d = (cur_len_q == '0) ? tap : cur_start_q;
        if (cur_len_d > best_len_q) begin
          best_len_d   = cur_len_d;
          best_start_d = cur_start_d;
        end
      end else begin
        cur_len_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_start_q  <= '0;
      cur_len_q    <= '0;
      best_start_q <= '0;
      best_len_q   <= '0;
    end else begin
      cur_start_q  <= cur_start_d;
      cur_len_q    <= cur_len_d;
      best_start_q <= best_start_d;
      best_len_q   <= best_len_d;
    end
  end

  assign found_o  = (best_len_q != '0);
  assign half_len = (best_len_q - 1'b1) >> 1;
  assign centre_o = found_o ? (best_start_q + TAP_W'(half_len)) : '0;
endmodule

// File: rtl/pc_tap_store.sv
module pc_tap_store #(
  parameter int NUM_CH = 96,
  parameter int TAP_W  = 5,
  parameter int CH_W   = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CH_W-1:0]  wch,
  input  logic [TAP_W-1:0] wtap,
  input  logic             wfail,
  input  logic [CH_W-1:0]  rch,
  output logic [TAP_W-1:0] rtap_o,
  output logic             rfail_o
);
  logic [TAP_W-1:0] tap_q [NUM_CH];
  logic [NUM_CH-1:0] fail_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ent
    logic sel;
    assign sel = we && (wch == CH_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tap_q[g]  <= '0;
        fail_q[g] <= 1'b0;
      end else if (sel) begin
        tap_q[g]  <= wtap;
        fail_q[g] <= wfail;
      end
    end
  end

  always_comb begin
    rtap_o  = '0;
    rfail_o = 1'b0;
    if (int'(rch) < NUM_CH) begin
      rtap_o  = tap_q[rch];
      rfail_o = fail_q[rch];
    end
  end
endmodule

// File: rtl/phase_cal_ctrl.sv
module phase_cal_ctrl #(
  parameter int NUM_CH = 96,
  parameter int TAPS   = 32,
  parameter int SETTLE = 16,
  parameter int WORDS  = 64,
  localparam int TAP_W = (TAPS > 1) ? $clog2(TAPS) : 1,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             word_valid_i,
  input  logic             match_i,
  output logic [TAP_W-1:0] tap_o,
  output logic             tap_load_o,
  output logic [CH_W-1:0]  chan_o,
  output logic             busy_o,
  output logic             done_o,
  input  logic [CH_W-1:0]  rd_ch_i,
  output logic [TAP_W-1:0] rd_tap_o,
  output logic             rd_fail_o
);
  import pc_pkg::*;

  localparam int CMAX  = (SETTLE > WORDS) ? SETTLE : WORDS;
  localparam int CNT_W = $clog2(CMAX + 1);

  pc_state_e        state_q, state_d;
  logic [TAP_W-1:0] tap_q, tap_d;
  logic [CH_W-1:0]  chan_q, chan_d;
  logic             all_ok_q, all_ok_d;
  logic             done_q, done_d;
  logic             cnt_clr, cnt_inc, win_clr, win_upd, st_we;
  logic [CNT_W-1:0] cnt;
  logic             found;
  logic [TAP_W-1:0] centre;

  pc_cycle_cnt #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc), .cnt_o(cnt)
  );

  pc_win_track #(.TAPS(TAPS), .TAP_W(TAP_W)) u_win (
    .clk(clk), .rst_n(rst_n), .clr(win_clr), .upd(win_upd),
    .pass(all_ok_q), .tap(tap_q), .found_o(found), .centre_o(centre)
  );

  pc_tap_store #(.NUM_CH(NUM_CH), .TAP_W(TAP_W), .CH_W(CH_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(st_we), .wch(chan_q), .wtap(centre),
    .wfail(!found), .rch(rd_ch_i), .rtap_o(rd_tap_o), .rfail_o(rd_fail_o)
  );

  always_comb begin
    state_d  = state_q;
    tap_d    = tap_q;
    chan_d   = chan_q;
    all_ok_d = all_ok_q;
    done_d   = done_q;
    cnt_clr  = 1'b0;
    cnt_inc  = 1'b0;
    win_clr  = 1'b0;
    win_upd  = 1'b0;
    st_we    = 1'b0;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        state_d = S_LOAD;
        chan_d  = '0;
        tap_d   = '0;
        win_clr = 1'b1;
        done_d  = 1'b0;
      end
      S_LOAD: begin
        state_d = S_SETTLE;
        cnt_clr = 1'b1;
      end
      S_SETTLE: if (cnt == CNT_W'(SETTLE - 1)) begin
        state_d  = S_MEAS;
        cnt_clr  = 1'b1;
        all_ok_d = 1'b1;
      end else begin
        cnt_inc = 1'b1;
      end
      S_MEAS: if (word_valid_i) begin
        cnt_inc  = 1'b1;
        all_ok_d = all_ok_q & match_i;
        if (cnt == CNT_W'(WORDS - 1)) state_d = S_EVAL;
      end
      S_EVAL: begin
        win_upd = 1'b1;
        if (tap_q == TAP_W'(TAPS - 1)) begin
          state_d = S_APPLY;
        end else begin
          tap_d   = tap_q + 1'b1;
          state_d = S_LOAD;
        end
      end
      S_APPLY: begin
        st_we   = 1'b1;
        state_d = S_NEXT;
      end
      S_NEXT: if (chan_q == CH_W'(NUM_CH - 1)) begin
        state_d = S_IDLE;
        done_d  = 1'b1;
      end else begin
        chan_d  = chan_q + 1'b1;
        tap_d   = '0;
        win_clr = 1'b1;
        state_d = S_LOAD;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      tap_q    <= '0;
      chan_q   <= '0;
      all_ok_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      tap_q    <= tap_d;
      chan_q   <= chan_d;
      all_ok_q <= all_ok_d;
      done_q   <= done_d;
    end
  end

  assign tap_load_o = (state_q == S_LOAD) || (state_q == S_APPLY);
  assign tap_o      = (state_q == S_APPLY) ? centre : tap_q;
  assign chan_o     = chan_q;
  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = done_q;
endmodule

// File: rtl/pc_checker.sv
module pc_checker #(
  parameter int TAP_W = 5,
  parameter int CH_W  = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             tap_load_o,
  input logic [TAP_W-1:0] tap_o,
  input logic [CH_W-1:0]  chan_o,
  input logic             busy_o,
  input logic             done_o
);
  a_r3_load_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tap_load_o |=> !tap_load_o);

  a_r9_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));

  a_r9_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o);

  a_r2_start_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> busy_o);

  a_r8_chan_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && (chan_o != $past(chan_o)))
      |-> (chan_o == CH_W'($past(chan_o) + 1'b1)));

  a_r2_first_tap: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (tap_load_o && tap_o == '0 && chan_o == '0));
endmodule

bind phase_cal_ctrl pc_checker #(.TAP_W(TAP_W), .CH_W(CH_W)) u_pc_checker (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .tap_load_o(tap_load_o),
  .tap_o(tap_o), .chan_o(chan_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/tb_phase_cal_ctrl.sv
module tb_phase_cal_ctrl;
  localparam int NCH = 6;
  localparam int NT  = 32;
  localparam int TW  = 5;
  localparam int CW  = 3;
  localparam int LIMIT = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, word_valid_i = 1'b0, match_i = 1'b0;
  logic [TW-1:0] tap_o, rd_tap_o;
  logic tap_load_o, busy_o, done_o, rd_fail_o;
  logic [CW-1:0] chan_o, rd_ch_i = '0;

  phase_cal_ctrl #(.NUM_CH(NCH), .TAPS(NT), .SETTLE(16), .WORDS(64)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .word_valid_i(word_valid_i),
    .match_i(match_i), .tap_o(tap_o), .tap_load_o(tap_load_o), .chan_o(chan_o),
    .busy_o(busy_o), .done_o(done_o), .rd_ch_i(rd_ch_i), .rd_tap_o(rd_tap_o),
    .rd_fail_o(rd_fail_o)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [NT-1:0] mask [NCH];
  logic [NT-1:0] hole [NCH];
  logic [TW-1:0] applied [NCH];
  int loads_ch [NCH];
  int loads_tot = 0, seq_err = 0, since = 0;
  logic [CW-1:0] prev_ch = '0;
  logic first_load = 1'b0, first_ok = 1'b0;
  logic [TW-1:0] cur_tap = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void best_of(input logic [NT-1:0] p, output bit fnd, output int ctr);
    int cs = 0, cl = 0, bs = 0, bl = 0;
    for (int t = 0; t < NT; t++) begin
      if (p[t]) begin
        if (cl == 0) cs = t;
        cl++;
        if (cl > bl) begin bl = cl; bs = cs; end
      end else cl = 0;
    end
    fnd = (bl != 0);
    ctr = fnd ? bs + (bl - 1) / 2 : 0;
  endfunction

  // link model: drives word stream for the tap currently held by the delay line
  initial begin
    forever begin
      @(negedge clk);
      if (tap_load_o) begin
        since = 0;
        cur_tap = tap_o;
        loads_tot++;
        loads_ch[chan_o]++;
        applied[chan_o] = tap_o;
        if (chan_o != prev_ch && chan_o != prev_ch + 1'b1) seq_err++; // R8
        if (first_load) begin
          first_ok = (chan_o == '0) && (tap_o == '0);
          first_load = 1'b0;
        end
        prev_ch = chan_o;
      end else since++;
      word_valid_i = ($urandom_range(0, 9) < 8);
      if (since == 20) begin
        word_valid_i = 1'b1;
        match_i = mask[chan_o][cur_tap] && !hole[chan_o][cur_tap];
      end else if (!word_valid_i || since < 15) match_i = 1'b0;  // ignored words
      else match_i = mask[chan_o][cur_tap];
    end
  end

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    while (cyc < LIMIT) begin
      @(negedge clk);
      if (done_o) begin ok = 1'b1; break; end
    end
  endtask

  task automatic run_and_check(input bit dbl_start);
    bit ok, fnd;
    int ctr;
    for (int c = 0; c < NCH; c++) loads_ch[c] = 0;
    loads_tot = 0; seq_err = 0; prev_ch = '0; first_load = 1'b1;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    check("R9 busy after start", int'(busy_o), 1);
    check("R9 done low while busy", int'(done_o), 0);
    if (dbl_start) begin
      repeat (3000) @(negedge clk);
      start_i = 1'b1; @(negedge clk); start_i = 1'b0;   // R2 ignored
    end
    wait_done(ok);
    if (!ok) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, LIMIT);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
    check("R9 busy low at done", int'(busy_o), 0);
    check("R2 first load lane0 tap0", int'(first_ok), 1);
    check("R8 lane order", seq_err, 0);
    check("R8 total loads", loads_tot, NCH * (NT + 1));
    for (int c = 0; c < NCH; c++) begin
      best_of(mask[c] & ~hole[c], fnd, ctr);
      rd_ch_i = CW'(c);
      @(negedge clk);
      check($sformatf("R6 R5 R4 stored tap lane %0d", c), int'(rd_tap_o), ctr);
      check($sformatf("R7 R10 fail flag lane %0d", c), int'(rd_fail_o), int'(!fnd));
      check($sformatf("R6 final load lane %0d", c), int'(applied[c]), ctr);
      check($sformatf("R3 loads lane %0d", c), loads_ch[c], NT + 1);
    end
    repeat (5) @(negedge clk);
    check("R9 done holds", int'(done_o), 1);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int c = 0; c < NCH; c++) begin mask[c] = '0; hole[c] = '0; end
    repeat (3) @(negedge clk);
    check("R1 busy", int'(busy_o), 0);
    check("R1 done", int'(done_o), 0);
    check("R1 load", int'(tap_load_o), 0);
    rd_ch_i = 3'd2; #1;
    check("R1 stored tap", int'(rd_tap_o), 0);
    rst_n = 1'b1;
    // directed windows
    mask[0] = '0;                               // R7 nothing passes
    mask[1] = '1;                               // full range -> 15
    mask[2] = 32'h0000_0F0F;                    // R5 tie, lower wins -> 1
    mask[3] = 32'h00FF_FF00; hole[3] = 32'h0004_0000;  // R4 single bad word splits
    mask[4] = 32'h8000_0000;                    // single top tap -> 31
    mask[5] = 32'h0000_0006;                    // two taps -> 1
    run_and_check(1'b1);
    // random windows
    for (int r = 0; r < 2; r++) begin
      for (int c = 0; c < NCH; c++) begin
        int lo = $urandom_range(0, NT - 1);
        int hi = $urandom_range(lo, NT - 1);
        mask[c] = '0; hole[c] = '0;
        for (int t = lo; t <= hi; t++) begin
          mask[c][t] = 1'b1;
          if ($urandom_range(0, 7) == 0) hole[c][t] = 1'b1;
        end
        if ($urandom_range(0, 3) == 0) mask[c][$urandom_range(0, NT - 1)] = 1'b1;
      end
      run_and_check(1'b0);
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule